// File: doc/BRIEF.md
# Dual Addressable Latch with Decode

This block holds two banks of four storage bits. Both banks share one 2-bit address, an active-low enable and an active-low clear control. Each bank has its own 1-bit data input and four outputs. The clear and enable levels together pick one of four modes:

- **Wipe.** Every output is forced low and the storage is cleared.
- **Decode.** The outputs act as a pair of 1-of-4 demultiplexers driven straight from address and data. The stored bits are left alone.
- **Hold.** The outputs show the stored bits.
- **Write.** The addressed bit of each bank takes that bank's data bit.

Storage is built from registers on a system clock, and enable acts as a level qualifier on each rising edge. Writing one address per clock lets a caller fill the banks in any order, or shift serial data into parallel form. With data tied high, decode mode gives two active-high address decoders.

Top module: `dual_addr_latch`

## Requirements
- R1: With clrN low and enN high, all eight outputs are low in the same cycle, whatever the address and data are.
- R2: A rising clock edge in wipe mode (clrN low, enN high) zeroes every stored bit, so a later hold mode shows all zeros.
- R3: With clrN and enN both low, output n of bank b equals dataIn[b] when addr equals n, and is low otherwise. This follows the inputs combinationally, with no clock edge needed.
- R4: Decode mode never changes the stored bits: the next hold mode shows the contents from before the decode.
- R5: With clrN and enN both high, the outputs keep their stored values across clock edges, and address and data changes have no effect.
- R6: With clrN high and enN low, each rising clock edge loads dataIn[b] into bit addr of bank b. All unaddressed bits keep their values.
- R7: The address is binary with addr[0] as its least significant bit. Bit n of bank b appears on q[b*4+n], and dataIn[b] feeds bank b only.
- R8: In write mode the outputs show the registered storage, so a written value appears on the outputs right after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; storage updates on its rising edge |
| clrN | input | 1 | Active-low clear control; one of the two mode-select lines |
| enN | input | 1 | Active-low enable; one of the two mode-select lines |
| addr | input | 2 | Bit select shared by both banks |
| dataIn | input | 2 | One data bit per bank; bit b feeds bank b |
| q | output | 8 | Outputs of both banks; bank b bit n is on q[b*4+n] |

## Verification
On every clock cycle, the assertions check the following:

- In wipe mode the outputs are zero (R1), and the hold that follows a wipe shows zeros (R2).
- In decode mode each bank drives at most one output (R3).
- Back-to-back hold cycles leave the outputs steady (R5).
- After a write, the addressed bit of each bank equals the data written and every other bit is unchanged (R6).

Some behaviour only the bench scenarios can show:

- Decode and wipe respond combinationally, between clock edges (R1, R3).
- Stored contents come back after a decode (R4).
- The exact mapping of address values and data bits to output positions (R7).

// File: rtl/dal_pkg.sv
package dal_pkg;

  typedef enum logic [1:0] {
    MODE_WIPE   = 2'b01,  // clrN=0, enN=1
    MODE_DECODE = 2'b00,  // clrN=0, enN=0
    MODE_HOLD   = 2'b11,  // clrN=1, enN=1
    MODE_WRITE  = 2'b10   // clrN=1, enN=0
  } dal_mode_e;

  typedef struct packed {
    logic wipeStore;   // clear every stored bit on this edge
    logic writeStore;  // load addressed bit on this edge
    logic showDecode;  // outputs driven by the demultiplexer
    logic forceLow;    // outputs driven to zero
  } dal_strobe_t;

endpackage

// File: rtl/dal_ctrl.sv
module dal_ctrl
  import dal_pkg::*;
(
  input  logic        clrN,
  input  logic        enN,
  output dal_strobe_t strobe
);

  dal_mode_e mode;

  assign mode = dal_mode_e'({clrN, enN});

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_WIPE: begin
        strobe.wipeStore = 1'b1;
        strobe.forceLow  = 1'b1;
      end
      MODE_DECODE: strobe.showDecode = 1'b1;
      MODE_WRITE:  strobe.writeStore = 1'b1;
      default:     strobe = '0;
    endcase
  end

endmodule

// File: rtl/dal_bank.sv
module dal_bank
  import dal_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  dal_strobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dataBit,
  output logic [WORDS-1:0]  bankOut
);

  logic [WORDS-1:0] stored;
  logic [WORDS-1:0] selOneHot;
  logic [WORDS-1:0] decodeOut;

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_bit
      assign selOneHot[i] = (addr == ADDR_W'(i));
      assign decodeOut[i] = selOneHot[i] & dataBit;

      always_ff @(posedge clk) begin
        if (strobe.wipeStore)
          stored[i] <= 1'b0;
        else if (strobe.writeStore && selOneHot[i])
          stored[i] <= dataBit;
      end
    end
  endgenerate

  always_comb begin
    if (strobe.forceLow)
      bankOut = '0;
    else if (strobe.showDecode)
      bankOut = decodeOut;
    else
      bankOut = stored;
  end

endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
  import dal_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int BANKS  = 2,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   clrN,
  input  logic                   enN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BANKS-1:0]       dataIn,
  output logic [BANKS*WORDS-1:0] q
);

  dal_strobe_t strobe;

  dal_ctrl u_ctrl (
    .clrN   (clrN),
    .enN    (enN),
    .strobe (strobe)
  );

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      dal_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .strobe  (strobe),
        .addr    (addr),
        .dataBit (dataIn[b]),
        .bankOut (q[b*WORDS +: WORDS])
      );
    end
  endgenerate

endmodule

// File: rtl/dal_checker.sv
module dal_checker #(
  parameter int ADDR_W = 2,
  parameter int BANKS  = 2,
  localparam int WORDS = 1 << ADDR_W
) (
  input logic                   clk,
  input logic                   clrN,
  input logic                   enN,
  input logic [ADDR_W-1:0]      addr,
  input logic [BANKS-1:0]       dataIn,
  input logic [BANKS*WORDS-1:0] q
);

  // Storage is undefined until the first wipe; checks arm after it.
  logic armed = 1'b0;
  always_ff @(posedge clk)
    if (!clrN && enN) armed <= 1'b1;

  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!armed)
    (!clrN && enN) |-> (q == '0)); // R1

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!armed)
    (!clrN && enN) ##1 (clrN && enN) |-> (q == '0)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
    (clrN && enN) ##1 (clrN && enN) |-> $stable(q)); // R5

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_b
      AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!armed)
        (!clrN && !enN) |-> $onehot0(q[b*WORDS +: WORDS])); // R3

      for (genvar i = 0; i < WORDS; i++) begin : g_i
        AST_WRITE_HIT: assert property (@(posedge clk) disable iff (!armed)
          (clrN && !enN && addr == ADDR_W'(i)) ##1 (clrN && enN)
          |-> (q[b*WORDS+i] == $past(dataIn[b]))); // R6

        AST_WRITE_MISS: assert property (@(posedge clk) disable iff (!armed)
          (clrN && !enN && addr != ADDR_W'(i)) ##1 clrN
          |-> (q[b*WORDS+i] == $past(q[b*WORDS+i]))); // R6
      end
    end
  endgenerate

endmodule

bind dual_addr_latch dal_checker #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_dal_checker (
  .clk    (clk),
  .clrN   (clrN),
  .enN    (enN),
  .addr   (addr),
  .dataIn (dataIn),
  .q      (q)
);

// File: tb/sim_dual_addr_latch.sv
`timescale 1ns/1ps
module sim_dual_addr_latch;

  logic       clk = 1'b0;
  logic       clrN, enN;
  logic [1:0] addr, dataIn;
  logic [7:0] q;
  int checks = 0;
  int errors = 0;
  logic [7:0] model;  // bench reference of the stored bits

  always #4 clk = ~clk;  // 125 MHz

  dual_addr_latch u0 (.clk(clk), .clrN(clrN), .enN(enN), .addr(addr),
                      .dataIn(dataIn), .q(q));

  typedef struct packed {
    logic       c;
    logic       e;
    logic [1:0] a;
    logic [1:0] d;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 2'd0, 2'b11, 8'h00, 4'd1}, // R1 wipe, reset state
    '{1'b1, 1'b0, 2'd0, 2'b11, 8'h11, 4'd6}, // R6 write bit0 both banks
    '{1'b1, 1'b0, 2'd2, 2'b01, 8'h15, 4'd7}, // R7 bank0 only, addr 2
    '{1'b1, 1'b0, 2'd3, 2'b10, 8'h95, 4'd7}, // R7 bank1 only, addr 3
    '{1'b1, 1'b1, 2'd1, 2'b11, 8'h95, 4'd5}, // R5 hold ignores inputs
    '{1'b0, 1'b0, 2'd1, 2'b11, 8'h22, 4'd3}, // R3 decode addr1
    '{1'b0, 1'b0, 2'd3, 2'b01, 8'h08, 4'd3}, // R3 decode addr3 bank0
    '{1'b1, 1'b1, 2'd0, 2'b00, 8'h95, 4'd4}, // R4 storage intact
    '{1'b1, 1'b0, 2'd0, 2'b00, 8'h84, 4'd8}, // R8 write zeros visible
    '{1'b1, 1'b0, 2'd2, 2'b10, 8'hC0, 4'd6}, // R6 mixed data
    '{1'b1, 1'b1, 2'd3, 2'b11, 8'hC0, 4'd5}, // R5
    '{1'b0, 1'b1, 2'd3, 2'b11, 8'h00, 4'd1}, // R1
    '{1'b1, 1'b1, 2'd3, 2'b11, 8'h00, 4'd2}, // R2 hold after wipe
    '{1'b0, 1'b0, 2'd0, 2'b10, 8'h10, 4'd3}, // R3 bank1 addr0
    '{1'b1, 1'b1, 2'd0, 2'b10, 8'h00, 4'd4}  // R4
  };

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected %h", tag, q, exp);
    end
  endtask

  function automatic logic [7:0] decodeOf(input logic [1:0] a, input logic [1:0] d);
    logic [7:0] r = '0;
    r[a]     = d[0];
    r[4 + a] = d[1];
    return r;
  endfunction

  task automatic drive(input logic c, input logic e, input logic [1:0] a,
                       input logic [1:0] d);
    clrN = c; enN = e; addr = a; dataIn = d;
  endtask

  // Apply inputs after a falling edge, clock once, update model, sample later.
  task automatic stepModel(input logic c, input logic e, input logic [1:0] a,
                           input logic [1:0] d, input string tag);
    @(negedge clk);
    drive(c, e, a, d);
    @(posedge clk);
    if (!c && e) model = '0;
    else if (c && !e) begin
      model[a] = d[0];
      model[4 + a] = d[1];
    end
    #2;
    if (!c && !e)     check(decodeOf(a, d), tag);
    else if (!c && e) check(8'h00, tag);
    else              check(model, tag);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive(1'b1, 1'b1, 2'd0, 2'b00);
    model = '0;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VECS[k].c, VECS[k].e, VECS[k].a, VECS[k].d);
      @(posedge clk);
      #2;
      checks++;
      if (q !== VECS[k].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d: q=%h expected %h", VECS[k].req, k,
                 q, VECS[k].exp);
      end
    end

    // Combinational response between edges
    stepModel(1'b1, 1'b0, 2'd1, 2'b11, "R6 write addr1");
    @(negedge clk);
    drive(1'b0, 1'b1, 2'd2, 2'b11); #1;
    check(8'h00, "R1 wipe without edge");
    drive(1'b0, 1'b0, 2'd2, 2'b01); #1;
    check(8'h04, "R3 decode without edge");
    drive(1'b1, 1'b1, 2'd2, 2'b01); #1;
    check(8'h22, "R4 stored back after decode");
    @(posedge clk); #2;
    check(8'h22, "R5 hold across edge");

    // Exhaustive decode sweep
    for (int a = 0; a < 4; a++)
      for (int d = 0; d < 4; d++)
        stepModel(1'b0, 1'b0, 2'(a), 2'(d), "R3 decode sweep");
    stepModel(1'b1, 1'b1, 2'd0, 2'b00, "R4 storage after sweep");

    // Exhaustive write sweep with hold checks
    for (int a = 0; a < 4; a++)
      for (int d = 0; d < 4; d++) begin
        stepModel(1'b1, 1'b0, 2'(a), 2'(d), "R7 write sweep");
        stepModel(1'b1, 1'b1, 2'(3 - a), 2'(~d), "R5 hold sweep");
      end

    stepModel(1'b0, 1'b1, 2'd1, 2'b11, "R1 final wipe");
    stepModel(1'b1, 1'b1, 2'd1, 2'b11, "R2 zeros after wipe");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule